// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Loader

This block is the digital front end of a two-channel 10-bit converter. A host shifts 16-bit command words into it over a three-wire serial link: a serial clock, a data line and an active-low frame strobe. The block captures each word and decodes it. It then updates three 10-bit registers: the code for channel A, the code for channel B, and one shared staging register. It also updates a speed-mode output and a spare control bit.

The staging register allows the two channels to change together. A host can write a staging-only command first and then a channel A command. The channel A command loads the new A code and, in the same update, moves the staged value into channel B. Both output codes therefore change on the same system clock edge.

The serial inputs are treated as asynchronous. They pass through synchronizer stages into the system clock domain. A command takes effect only when its frame closes after exactly sixteen serial clock edges.

Top module: `dual_dac_loader`

## Requirements
- R1: While `frame_n` is low, each rising edge of `ser_clk` samples one bit of `ser_dat`. The first bit sampled is bit 15 of the command word and the last is bit 0. The command takes effect after `frame_n` returns high.
- R2: The 10-bit code is taken from word bits 11..2, with bit 11 as the code MSB. Word bits 1 and 0 have no effect.
- R3: When bit 15 is 1, `code_a` loads the code. In the same update, `code_b` loads the staging register's value from before the command. The staging register keeps its value.
- R4: When bit 15 is 0 and bit 12 is 0, both the staging register and `code_b` load the code. `code_a` is unchanged.
- R5: When bit 15 is 0 and bit 12 is 1, only the staging register loads the code. `code_a` and `code_b` are unchanged.
- R6: On every accepted command, `fast_mode` takes the value of word bit 14 (1 = fast, 0 = slow).
- R7: After reset, `code_a`, `code_b` and the staging register hold zero, and `fast_mode` and `aux_ctl` are 0.
- R8: A frame with fewer or more than 16 serial clock rising edges is dropped. No output and no internal register changes.
- R9: On every accepted command, `aux_ctl` takes the value of word bit 13. This bit has no effect on the codes.
- R10: When a single command changes both `code_a` and `code_b`, both change in the same system clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_clk | input | 1 | Serial bit clock; sampled on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| frame_n | input | 1 | Active-low frame strobe; its rising edge commits the command |
| code_a | output | 10 | Converter code for channel A |
| code_b | output | 10 | Converter code for channel B |
| fast_mode | output | 1 | Speed mode from the last accepted command |
| aux_ctl | output | 1 | Spare control bit from the last accepted command |

## Verification
The key corner case is a channel A write that copies the staging register into channel B. There are two cases.
- If the staging register was last loaded by a channel B write, `code_b` must keep its value. A design that cleared channel B here, or loaded it with the A code, would give a wrong `code_b`.
- If a staging-only write came first, `code_b` must take that staged code in the same cycle that `code_a` moves. A design that updated the two channels in different cycles, or copied the staging register after it had been changed, would fail this check.

Frames with fifteen and seventeen edges are sent; a design that counted the edges wrongly or decoded on a partial frame would change the outputs. Codes with a single bit set at each end of the field show whether the bit order or the field position has slipped. Garbage in the two low bits shows whether the don't-care bits leak into the code.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  localparam int WORD_W   = 16;
  localparam int CODE_W   = 10;
  localparam int CODE_LSB = 2;
  localparam int BIT_CHAN = 15;  // 1: channel A command
  localparam int BIT_SPD  = 14;  // speed mode
  localparam int BIT_AUX  = 13;  // spare control bit
  localparam int BIT_STG  = 12;  // staging-only when channel bit is 0

  typedef struct packed {
    logic              to_a;
    logic              stage_only;
    logic              fast;
    logic              aux;
    logic [CODE_W-1:0] code;
  } cmd_t;

  function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
    cmd_t c;
    c.to_a       = w[BIT_CHAN];
    c.stage_only = w[BIT_STG];
    c.fast       = w[BIT_SPD];
    c.aux        = w[BIT_AUX];
    c.code       = w[CODE_LSB +: CODE_W];
    return c;
  endfunction
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int               WIDTH   = 1,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d;
    end else begin : g_next
      assign stage_d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else        stage_q[s] <= stage_d;
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdat,
  input  logic              frame_n,
  output logic              word_vld,
  output logic [WORD_W-1:0] word
);
  localparam int              CNT_W    = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic              sclk_q, frame_q, vld_q;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_d;
  logic              sclk_rise, frame_fall, frame_rise;
  logic              sh_en, cnt_en;

  assign sclk_rise  = sclk & ~sclk_q;
  assign frame_fall = ~frame_n & frame_q;
  assign frame_rise = frame_n & ~frame_q;

  // next-state logic
  always_comb begin
    sh_en  = 1'b0;
    cnt_en = 1'b0;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    if (frame_fall) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (!frame_n && sclk_rise) begin
      sh_en  = 1'b1;
      sh_d   = {sh_q[WORD_W-2:0], sdat};
      cnt_en = (cnt_q != CNT_OVER);
      cnt_d  = cnt_q + 1'b1;
    end
    vld_d = frame_rise && (cnt_q == CNT_FULL);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      frame_q <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      frame_q <= frame_n;
      vld_q   <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_OVER;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign word_vld = vld_q;
  assign word     = sh_q;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_loader_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [WORD_W-1:0] cmd_word,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic [CODE_W-1:0] stage,
  output logic              fast,
  output logic              aux
);
  cmd_t              cmd;
  logic [CODE_W-1:0] a_q, b_q, s_q, a_d, b_d, s_d;
  logic              f_q, x_q;
  logic              en_a, en_b, en_s, en_m;

  assign cmd = decode_word(cmd_word);

  // next-state and enables
  always_comb begin
    en_m = cmd_vld;
    en_a = cmd_vld &  cmd.to_a;
    en_s = cmd_vld & ~cmd.to_a;
    en_b = cmd_vld & (cmd.to_a | ~cmd.stage_only);
    a_d  = cmd.code;
    s_d  = cmd.code;
    b_d  = cmd.to_a ? s_q : cmd.code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (en_a) a_q <= a_d;
      if (en_b) b_q <= b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    s_q <= '0;
    else if (en_s) s_q <= s_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= 1'b0;
      x_q <= 1'b0;
    end else if (en_m) begin
      f_q <= cmd.fast;
      x_q <= cmd.aux;
    end
  end

  assign code_a = a_q;
  assign code_b = b_q;
  assign stage  = s_q;
  assign fast   = f_q;
  assign aux    = x_q;
endmodule

// File: rtl/dual_dac_loader.sv
module dual_dac_loader
  import dac_loader_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              frame_n,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              fast_mode,
  output logic              aux_ctl
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [2:0]        ser_s;
  logic              rx_vld;
  logic [WORD_W-1:0] rx_word;
  logic [CODE_W-1:0] stage_code;

  // reset: asserted asynchronously, released on clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  dac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({frame_n, ser_dat, ser_clk}),
    .q     (ser_s)
  );

  dac_frame_rx #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .sclk     (ser_s[0]),
    .sdat     (ser_s[1]),
    .frame_n  (ser_s[2]),
    .word_vld (rx_vld),
    .word     (rx_word)
  );

  dac_reg_bank u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_vld  (rx_vld),
    .cmd_word (rx_word),
    .code_a   (code_a),
    .code_b   (code_b),
    .stage    (stage_code),
    .fast     (fast_mode),
    .aux      (aux_ctl)
  );
endmodule

// File: rtl/dual_dac_loader_chk.sv
module dual_dac_loader_chk
  import dac_loader_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_vld,
  input logic [WORD_W-1:0] cmd_word,
  input logic [CODE_W-1:0] stage,
  input logic [CODE_W-1:0] code_a,
  input logic [CODE_W-1:0] code_b,
  input logic              fast_mode,
  input logic              aux_ctl
);
  // R3 and R10: channel A write moves the old staging value to B in the same edge
  a_r3_a_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_word[BIT_CHAN]) |=>
      (code_a == $past(cmd_word[CODE_LSB +: CODE_W])) && (code_b == $past(stage)) && $stable(stage));

  // R4
  a_r4_b_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_word[BIT_CHAN] && !cmd_word[BIT_STG]) |=>
      (code_b == $past(cmd_word[CODE_LSB +: CODE_W])) && (stage == code_b) && $stable(code_a));

  // R5
  a_r5_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && !cmd_word[BIT_CHAN] && cmd_word[BIT_STG]) |=>
      $stable(code_a) && $stable(code_b) && (stage == $past(cmd_word[CODE_LSB +: CODE_W])));

  // R6, R9
  a_r6_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld |=> (fast_mode == $past(cmd_word[BIT_SPD])) && (aux_ctl == $past(cmd_word[BIT_AUX])));

  // R8: without a committed command nothing moves
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> $stable(code_a) && $stable(code_b) && $stable(stage)
                 && $stable(fast_mode) && $stable(aux_ctl));
endmodule

bind dual_dac_loader dual_dac_loader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_vld   (rx_vld),
  .cmd_word  (rx_word),
  .stage     (stage_code),
  .code_a    (code_a),
  .code_b    (code_b),
  .fast_mode (fast_mode),
  .aux_ctl   (aux_ctl)
);

// File: tb/dual_dac_loader_test.sv
module dual_dac_loader_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic       frame_n = 1'b1;
  logic [9:0] code_a, code_b;
  logic       fast_mode, aux_ctl;

  int total = 0;
  int bad = 0;
  int ta, tb;
  logic [9:0] ea, eb, es;
  logic       ef, ex;

  always #2 clk = ~clk;  // 250 MHz

  dual_dac_loader uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .frame_n(frame_n),
    .code_a(code_a), .code_b(code_b), .fast_mode(fast_mode), .aux_ctl(aux_ctl)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // command word: chan, speed, aux, stage-only, code, two low bits
  function automatic logic [15:0] mk(input logic ch, input logic sp, input logic ax,
                                     input logic so, input logic [9:0] c, input logic [1:0] lo);
    return {ch, sp, ax, so, c, lo};
  endfunction

  // model of the register update from the requirements
  task automatic model(input logic [15:0] w);
    ef = w[14];
    ex = w[13];
    if (w[15]) begin
      eb = es;
      ea = w[11:2];
    end else begin
      es = w[11:2];
      if (!w[12]) eb = w[11:2];
    end
  endtask

  // shift nbits of w (MSB first, zeros past bit 0), then record change cycles
  task automatic send(input logic [15:0] w, input int nbits);
    logic [9:0] pa, pb;
    frame_n = 1'b0;
    #40;
    for (int i = 0; i < nbits; i++) begin
      ser_dat = (i < 16) ? w[15-i] : 1'b0;
      #20 ser_clk = 1'b1;
      #20 ser_clk = 1'b0;
    end
    #20 frame_n = 1'b1;
    ta = -1;
    tb = -1;
    @(negedge clk);
    pa = code_a;
    pb = code_b;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (code_a != pa && ta < 0) ta = k;
      if (code_b != pb && tb < 0) tb = k;
      pa = code_a;
      pb = code_b;
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " code_a"}, code_a, ea);
    chk({tag, " code_b"}, code_b, eb);
    chk({tag, " fast_mode"}, fast_mode, ef);
    chk({tag, " aux_ctl"}, aux_ctl, ex);
  endtask

  task automatic t_reset;
    ea = '0; eb = '0; es = '0; ef = 1'b0; ex = 1'b0;
    check_all("R7 reset");
  endtask

  task automatic t_write_b;
    logic [15:0] w;
    w = mk(1'b0, 1'b1, 1'b0, 1'b0, 10'h3FF, 2'b10);
    send(w, 16); model(w);
    check_all("R4 R6 channel B write");
    w = mk(1'b0, 1'b0, 1'b0, 1'b0, 10'h001, 2'b11);
    send(w, 16); model(w);
    check_all("R1 R2 code LSB, low bits ignored");
    w = mk(1'b0, 1'b1, 1'b0, 1'b0, 10'h200, 2'b00);
    send(w, 16); model(w);
    check_all("R1 R2 code MSB");
  endtask

  task automatic t_write_a_plain;
    logic [15:0] w;
    w = mk(1'b1, 1'b0, 1'b1, 1'b0, 10'h155, 2'b01);
    send(w, 16); model(w);
    check_all("R3 R9 A write keeps B");
    chk("R3 B value unchanged", code_b, 10'h200);
  endtask

  task automatic t_stage_then_a;
    logic [15:0] w;
    w = mk(1'b0, 1'b0, 1'b0, 1'b1, 10'h0AA, 2'b00);
    send(w, 16); model(w);
    check_all("R5 staging-only write");
    chk("R5 no B change seen", tb, -1);
    w = mk(1'b1, 1'b0, 1'b0, 1'b1, 10'h2C3, 2'b00);
    send(w, 16); model(w);
    check_all("R3 A write copies staged code");
    chk("R3 B took staged value", code_b, 10'h0AA);
    chk("R10 A changed", (ta >= 0) ? 1 : 0, 1);
    chk("R10 same cycle", tb, ta);
  endtask

  task automatic t_bad_frames;
    send(mk(1'b1, 1'b1, 1'b0, 1'b0, 10'h111, 2'b00), 15);
    check_all("R8 short frame dropped");
    send(mk(1'b0, 1'b1, 1'b1, 1'b0, 10'h111, 2'b00), 17);
    check_all("R8 long frame dropped");
    // staging must also be untouched: an A write reveals it in B
    send(mk(1'b0, 1'b0, 1'b0, 1'b1, 10'h155, 2'b00), 14);
    send(mk(1'b1, 1'b0, 1'b0, 1'b0, 10'h001, 2'b00), 16);
    model(mk(1'b1, 1'b0, 1'b0, 1'b0, 10'h001, 2'b00));
    check_all("R8 staging untouched by dropped frame");
  endtask

  task automatic t_aux;
    logic [15:0] w;
    w = mk(1'b0, 1'b1, 1'b1, 1'b0, 10'h0F0, 2'b00);
    send(w, 16); model(w);
    check_all("R9 aux set, R6 fast");
    w = mk(1'b0, 1'b0, 1'b0, 1'b1, 10'h30C, 2'b11);
    send(w, 16); model(w);
    check_all("R9 aux cleared on staging write, R6 slow");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_write_b();
    t_write_a_plain();
    t_stage_then_a();
    t_bad_frames();
    t_aux();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule